// File: doc/BRIEF.md
# Two-Level Preemptive Interrupt Controller

This block arbitrates six interrupt sources for a small 8-bit processor core. Every source has its own enable bit and a one-bit priority level, and a global enable masks them all. Each cycle the block finds the winning source among those allowed to interrupt and registers it. It then presents a request, a vector address and the winner's level to the core, and holds them until the core acknowledges.

Nesting is tracked with one in-service bit per level. An acknowledge sets the bit for the level being taken. A return pulse clears the high bit if it is set, and otherwise clears the low bit. A request is granted only when no interrupt of equal or higher level is in service. So a high-level request can interrupt a low-level handler, and anything else waits.

The two external inputs and the two basic timers keep their request flags inside the block. Timer flags and edge-mode external flags are cleared when their interrupt is acknowledged. Level-mode external flags follow the pin and are never cleared on acknowledge. The serial and third-timer flags are kept outside the block and cleared by software. The block only ORs each pair of them into one request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `irq_req` is 0, `in_service` is 2'b00 and `hw_flags` is 4'b0000.
- R2: Within one level, the lowest source index wins. The order is external 0, timer 0, external 1, timer 1, serial, timer 2 (indices 0 to 5). The vector is 8'h03 + 8 × index, giving 03h, 0Bh, 13h, 1Bh, 23h and 2Bh.
- R3: An eligible pending high-level source (`src_hi` bit = 1) wins over every low-level source, whatever the polling order. `irq_lvl` shows the level of the presented source.
- R4: A source whose `src_en` bit is 0 never raises a request, and no source raises one while `glob_en` is 0. A flag that is held keeps pending and is presented once it is enabled again.
- R5: While `in_service[1]` is set, no request is presented. While only `in_service[0]` is set, only high-level sources are presented.
- R6: A high-level request is presented and granted while a low-level handler is in service. Afterwards both in-service bits are set.
- R7: `irq_ack` while `irq_req` is 1 sets `in_service[irq_lvl]` and lowers `irq_req` at the same clock edge.
- R8: `irq_reti` clears `in_service[1]` if it is set and leaves `in_service[0]` unchanged. Otherwise it clears `in_service[0]`.
- R9: Timer 0 and timer 1 flags are set by a one-cycle `tmr_set` pulse. The `hw_flags` bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1. A timer flag is cleared by the acknowledge of that timer and not by the acknowledge of any other source.
- R10: With `ext_edge[k]` = 1, a rising edge of `ext_in[k]` sets the external flag, the acknowledge clears it, and a pin held high does not set it again. With `ext_edge[k]` = 0, the flag is the pin value from one cycle earlier, and an acknowledge does not clear it.
- R11: The serial source requests when either serial flag input is high. The timer-2 source requests when either timer-2 flag input is high.
- R12: A request is registered once before it is presented. A change on a serial or timer-2 input shows on `irq_req`/`irq_vec` after one clock edge. A timer pulse or an external pin change shows after two clock edges: one edge sets the internal flag and one registers the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enable, index as in R2 |
| src_hi | input | 6 | Per-source level, 1 = high |
| ext_edge | input | 2 | External trigger mode, 1 = edge, 0 = level |
| ext_in | input | 2 | External request pins, active high, already synchronized |
| tmr_set | input | 2 | One-cycle pulses that set the timer 0 / timer 1 flags |
| ser_tx_flag | input | 1 | Serial transmit flag |
| ser_rx_flag | input | 1 | Serial receive flag |
| t2_ovf_flag | input | 1 | Timer-2 overflow flag |
| t2_ext_flag | input | 1 | Timer-2 external flag |
| irq_ack | input | 1 | Core takes the presented request |
| irq_reti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector address of the presented source |
| irq_lvl | output | 1 | Level of the presented source |
| hw_flags | output | 4 | Internal flags: external 0, timer 0, external 1, timer 1 |
| in_service | output | 2 | In-service bits, bit 1 = high level |

## Verification
The serial and timer-2 inputs reach `irq_req` one edge after they are driven. Timer pulses and external pins take two edges. After an acknowledge, `irq_req`, `in_service` and `hw_flags` all change at that one edge. After a return, the in-service bits change at once, but a request that was waiting appears one edge later. The reason is that the presentation register sampled the old in-service state. The bench drives every input on a falling edge and waits exactly that number of falling edges before it samples. Waiting checks add spare edges to show that a blocked request stays absent.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC     = 6;
    localparam int SRC_W    = 3;
    localparam int NLVL     = 2;
    localparam int NEXT     = 2;
    localparam int NTMR     = 2;
    localparam int NHW      = NEXT + NTMR;
    localparam int VEC_W    = 8;
    localparam logic [VEC_W-1:0] VEC_BASE = 8'h03;
    localparam logic [VEC_W-1:0] VEC_STEP = 8'h08;

    typedef enum logic [SRC_W-1:0] {
        SRC_X0 = 3'd0,
        SRC_T0 = 3'd1,
        SRC_X1 = 3'd2,
        SRC_T1 = 3'd3,
        SRC_SP = 3'd4,
        SRC_T2 = 3'd5
    } src_e;

    typedef struct packed {
        logic valid;
        logic lvl;
        src_e src;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        return VEC_BASE + VEC_STEP * VEC_W'(s);
    endfunction
endpackage

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] ext_edge,
    input  logic [NEXT-1:0] ext_in,
    input  logic [NTMR-1:0] tmr_set,
    input  logic            clr_valid,
    input  src_e            clr_src,
    output logic [NHW-1:0]  flags
);
    // bit 2k is external k, bit 2k+1 is timer k
    for (genvar k = 0; k < NEXT; k++) begin : g_ext
        logic pin_q;
        logic hit;
        assign hit = clr_valid && (clr_src == src_e'(SRC_W'(2 * k)));
        always_ff @(posedge clk) begin
            if (rst) begin
                pin_q        <= 1'b0;
                flags[2*k]   <= 1'b0;
            end else begin
                pin_q <= ext_in[k];
                if (!ext_edge[k])
                    flags[2*k] <= ext_in[k];
                else if (ext_in[k] && !pin_q)
                    flags[2*k] <= 1'b1;
                else if (hit)
                    flags[2*k] <= 1'b0;
            end
        end
    end

    for (genvar k = 0; k < NTMR; k++) begin : g_tmr
        logic hit;
        assign hit = clr_valid && (clr_src == src_e'(SRC_W'(2 * k + 1)));
        always_ff @(posedge clk) begin
            if (rst)
                flags[2*k+1] <= 1'b0;
            else if (tmr_set[k])
                flags[2*k+1] <= 1'b1;
            else if (hit)
                flags[2*k+1] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] hi,
    input  logic [NLVL-1:0] ins,
    output pick_t           best
);
    logic            hi_ok;
    logic            lo_ok;
    logic [NSRC-1:0] req_hi;
    logic [NSRC-1:0] req_lo;

    // a level may interrupt only if nothing at its level or above is active
    assign hi_ok  = !ins[1];
    assign lo_ok  = !ins[1] && !ins[0];
    assign req_hi = pend & hi  & {NSRC{hi_ok}};
    assign req_lo = pend & ~hi & {NSRC{lo_ok}};

    always_comb begin
        best = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_lo[i]) begin
                best.valid = 1'b1;
                best.lvl   = 1'b0;
                best.src   = src_e'(i[SRC_W-1:0]);
            end
        end
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_hi[i]) begin
                best.valid = 1'b1;
                best.lvl   = 1'b1;
                best.src   = src_e'(i[SRC_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            take_lvl,
    input  logic            reti,
    output logic [NLVL-1:0] ins
);
    logic [NLVL-1:0] ins_nx;

    always_comb begin
        ins_nx = ins;
        if (reti) begin
            if (ins[1]) ins_nx[1] = 1'b0;
            else        ins_nx[0] = 1'b0;
        end
        if (take) ins_nx[take_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ins <= '0;
        else     ins <= ins_nx;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             glob_en,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  src_hi,
    input  logic [NEXT-1:0]  ext_edge,
    input  logic [NEXT-1:0]  ext_in,
    input  logic [NTMR-1:0]  tmr_set,
    input  logic             ser_tx_flag,
    input  logic             ser_rx_flag,
    input  logic             t2_ovf_flag,
    input  logic             t2_ext_flag,
    input  logic             irq_ack,
    input  logic             irq_reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_lvl,
    output logic [NHW-1:0]   hw_flags,
    output logic [NLVL-1:0]  in_service
);
    pick_t           pick_c;
    pick_t           pick_q;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] pend;
    logic            take;

    assign take = irq_ack && pick_q.valid;

    irq_flag_unit u_flags (
        .clk       (clk),
        .rst       (rst),
        .ext_edge  (ext_edge),
        .ext_in    (ext_in),
        .tmr_set   (tmr_set),
        .clr_valid (take),
        .clr_src   (pick_q.src),
        .flags     (hw_flags)
    );

    always_comb begin
        raw         = '0;
        raw[SRC_X0] = hw_flags[0];
        raw[SRC_T0] = hw_flags[1];
        raw[SRC_X1] = hw_flags[2];
        raw[SRC_T1] = hw_flags[3];
        raw[SRC_SP] = ser_tx_flag | ser_rx_flag;
        raw[SRC_T2] = t2_ovf_flag | t2_ext_flag;
    end

    assign pend = raw & src_en & {NSRC{glob_en}};

    irq_pick u_pick (
        .pend (pend),
        .hi   (src_hi),
        .ins  (in_service),
        .best (pick_c)
    );

    irq_nest u_nest (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .take_lvl (pick_q.lvl),
        .reti     (irq_reti),
        .ins      (in_service)
    );

    // winner held one cycle; an acknowledge withdraws it at once
    always_ff @(posedge clk) begin
        if (rst)
            pick_q <= '0;
        else if (take)
            pick_q.valid <= 1'b0;
        else
            pick_q <= pick_c;
    end

    assign irq_req = pick_q.valid;
    assign irq_vec = vec_of(pick_q.src);
    assign irq_lvl = pick_q.lvl;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             glob_en,
    input logic [NSRC-1:0]  src_en,
    input logic [NSRC-1:0]  src_hi,
    input logic [NEXT-1:0]  ext_edge,
    input logic [NEXT-1:0]  ext_in,
    input logic [NTMR-1:0]  tmr_set,
    input logic             ser_tx_flag,
    input logic             ser_rx_flag,
    input logic             t2_ovf_flag,
    input logic             t2_ext_flag,
    input logic             irq_ack,
    input logic             irq_reti,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_lvl,
    input logic [NHW-1:0]   hw_flags,
    input logic [NLVL-1:0]  in_service
);
    // R7
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> !irq_req);

    // R7
    ack_marks_high_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && irq_lvl) |=> in_service[1]);

    // R5
    high_busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        in_service[1] |-> !irq_req);

    // R5
    low_busy_high_only_chk: assert property (@(posedge clk) disable iff (rst)
        (in_service[0] && irq_req) |-> irq_lvl);

    // R8
    reti_pops_high_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_reti && in_service[1] && !irq_ack)
            |=> (!in_service[1] && in_service[0] == $past(in_service[0])));

    // R4
    global_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> !irq_req);

    // R2
    vector_grid_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec <= 8'h2B));

    // R9
    timer0_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && irq_vec == 8'h0B && !tmr_set[0]) |=> !hw_flags[1]);

    // R10
    level_follows_pin_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_edge[1] |=> hw_flags[2] == $past(ext_in[1]));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (.*);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       glob_en = 1'b1;
    logic [5:0] src_en = 6'h3F;
    logic [5:0] src_hi = 6'h00;
    logic [1:0] ext_edge = 2'b00;
    logic [1:0] ext_in = 2'b00;
    logic [1:0] tmr_set = 2'b00;
    logic       ser_tx_flag = 1'b0;
    logic       ser_rx_flag = 1'b0;
    logic       t2_ovf_flag = 1'b0;
    logic       t2_ext_flag = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_reti = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_lvl;
    logic [3:0] hw_flags;
    logic [1:0] in_service;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut_i (.*);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_tmr(input logic [1:0] which);
        tmr_set = which;
        step(1);
        tmr_set = 2'b00;
        step(1);
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
    endtask

    task automatic do_reti();
        irq_reti = 1'b1;
        step(1);
        irq_reti = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req", irq_req, 0);
        chk("R1 in_service", in_service, 0);
        chk("R1 flags", hw_flags, 0);
    endtask

    task automatic t_direct_sources();
        ser_rx_flag = 1; t2_ovf_flag = 1; step(1);
        chk("R12 one-edge req", irq_req, 1);
        chk("R2 serial before t2", irq_vec, 8'h23);
        ser_rx_flag = 0; ser_tx_flag = 1; step(1);
        chk("R11 serial tx alone", irq_vec, 8'h23);
        ser_tx_flag = 0; step(1);
        chk("R11 t2 overflow", irq_vec, 8'h2B);
        t2_ovf_flag = 0; t2_ext_flag = 1; step(1);
        chk("R11 t2 ext alone", {irq_req, irq_vec}, {1'b1, 8'h2B});
        t2_ext_flag = 0; step(1);
        chk("R11 all low", irq_req, 0);
    endtask

    task automatic t_timer_order();
        pulse_tmr(2'b11);
        chk("R2 timer0 first", {irq_req, irq_lvl, irq_vec}, {2'b10, 8'h0B});
        chk("R9 both flags", hw_flags, 4'b1010);
        do_ack();
        chk("R7 req dropped", irq_req, 0);
        chk("R7 low in service", in_service, 2'b01);
        chk("R9 timer0 cleared only", hw_flags, 4'b1000);
        step(2);
        chk("R5 low waits on low", irq_req, 0);
        do_reti();
        chk("R8 low popped", in_service, 2'b00);
        step(1);
        chk("R2 timer1 next", {irq_req, irq_vec}, {1'b1, 8'h1B});
        do_ack();
        chk("R9 timer1 cleared", hw_flags, 4'b0000);
        do_reti(); step(1);
        chk("R8 idle", {irq_req, in_service}, 3'b000);
    endtask

    task automatic t_level_priority();
        src_hi = 6'b001000;
        pulse_tmr(2'b11);
        chk("R3 high wins", {irq_req, irq_lvl, irq_vec}, {2'b11, 8'h1B});
        do_ack();
        chk("R7 high in service", in_service, 2'b10);
        step(2);
        chk("R5 low waits on high", irq_req, 0);
        do_reti(); step(1);
        chk("R3 low after", {irq_req, irq_lvl, irq_vec}, {2'b10, 8'h0B});
        do_ack(); do_reti(); step(1);
        src_hi = 6'h00;
    endtask

    task automatic t_preempt();
        src_hi = 6'b001000;
        pulse_tmr(2'b01);
        chk("R6 low presented", irq_vec, 8'h0B);
        do_ack();
        chk("R6 low running", in_service, 2'b01);
        pulse_tmr(2'b10);
        chk("R6 high preempts", {irq_req, irq_lvl, irq_vec}, {2'b11, 8'h1B});
        do_ack();
        chk("R6 both in service", in_service, 2'b11);
        do_reti();
        chk("R8 high popped first", in_service, 2'b01);
        step(1);
        chk("R8 low resumed quiet", irq_req, 0);
        do_reti();
        chk("R8 low popped", in_service, 2'b00);
        src_hi = 6'h00;
    endtask

    task automatic t_enables();
        src_en = 6'b111101;
        pulse_tmr(2'b01); step(2);
        chk("R4 source masked", irq_req, 0);
        glob_en = 0; src_en = 6'h3F; step(2);
        chk("R4 global masked", irq_req, 0);
        chk("R4 flag held", hw_flags, 4'b0010);
        glob_en = 1; step(1);
        chk("R4 re-enabled", {irq_req, irq_vec}, {1'b1, 8'h0B});
        do_ack(); do_reti(); step(1);
    endtask

    task automatic t_external();
        ext_edge = 2'b01;
        ext_in[0] = 1; step(2);
        chk("R10 edge flag", hw_flags, 4'b0001);
        chk("R10 ext0 vector", {irq_req, irq_vec}, {1'b1, 8'h03});
        do_ack();
        chk("R10 edge cleared", hw_flags, 4'b0000);
        step(2);
        chk("R10 held pin no reset", hw_flags, 4'b0000);
        do_reti(); step(2);
        chk("R10 edge idle", irq_req, 0);
        ext_in[0] = 0; step(1);
        ext_in[1] = 1; step(2);
        chk("R10 level vector", {irq_req, irq_vec}, {1'b1, 8'h13});
        do_ack();
        chk("R10 level not cleared", hw_flags, 4'b0100);
        do_reti(); step(2);
        chk("R10 level re-presented", {irq_req, irq_vec}, {1'b1, 8'h13});
        ext_in[1] = 0; step(1);
        chk("R10 level follows pin", hw_flags, 4'b0000);
        step(1);
        chk("R10 level req gone", irq_req, 0);
    endtask

    initial begin
        step(3);
        t_reset();
        rst = 0;
        step(1);
        t_reset();
        t_direct_sources();
        t_timer_order();
        t_level_priority();
        t_preempt();
        t_enables();
        t_external();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule